// File: doc/BRIEF.md
# Split-Screen Display Address Generator

This block produces the display-memory word addresses for a raster LCD controller whose frame can be split into two stacked regions. The upper region always comes from the Screen 1 start address. After a programmable number of lines, the lower region comes from the Screen 2 start address. The on-screen order is fixed and does not depend on where either start address lies in memory. Both addresses may even be equal.

A panel timing generator supplies a frame pulse and one line pulse per line. For each accepted line pulse the block emits one fetch strobe per word of the line, with an incrementing word address. Between lines the line base address advances by the word stride. At the split point the base reloads from the Screen 2 start address, so Screen 2 starts at the left-most pixel. A byte-wide write port fills shadow copies of the start-address and size registers. These shadow copies become active only at a frame pulse. Split operation is never used in portrait orientation.

Top module: `split_addr_gen`

## Requirements
- R1: Registers are written one byte per cycle. Offset 0x0C holds Screen 1 start bits 7:0, 0x0D holds bits 15:8, 0x0E holds Screen 2 start bits 7:0, 0x0F holds bits 15:8, 0x10 holds Screen 1 line count bits 7:0 and 0x11 holds its upper bits. A write to any other offset changes nothing.
- R2: The cycle after a frame pulse, no fetch strobe is active and the region flag is 0. The first line of the frame then starts at the Screen 1 start address.
- R3: An accepted line pulse with stride N (N ≥ 1) produces exactly N fetch strobes on consecutive cycles, beginning the cycle after the pulse is sampled. The addresses are base, base+1, …, base+N−1, modulo 2^16.
- R4: Each line base equals the previous line base plus the stride, unless a split occurs at that line.
- R5: In landscape mode with a Screen 1 line count S where 0 < S < panel lines, line S starts at the Screen 2 start address and the region flag becomes 1. Later lines add the stride to this base. This holds whichever start address is numerically larger.
- R6: When the Screen 1 line count is 0, or is equal to or greater than the panel line count, every line comes from Screen 1 and the region flag stays 0.
- R7: When the portrait input is 1, the Screen 2 start address is never used and the region flag stays 0.
- R8: The following line pulses produce no fetch strobes: a pulse arriving after the panel line count of lines in the frame, a pulse arriving while a line is still being fetched, and a pulse arriving while the stride is 0. A pulse ignored for a zero stride does not advance the line.
- R9: Register writes made during a frame do not affect that frame. They take effect from the next frame pulse onward.
- R10: Equal Screen 1 and Screen 2 start addresses are handled like any other values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| line_start | input | 1 | One-cycle pulse requesting the fetch of one line |
| panel_lines | input | LINE_W | Physical panel height in lines |
| word_stride | input | STRIDE_W | Words per line, also the line-to-line address step |
| portrait | input | 1 | 1 selects portrait orientation (no split) |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| fetch | output | 1 | Fetch strobe, one per word |
| word_addr | output | 16 | Word address valid with fetch |
| region | output | 1 | 0 while Screen 1 lines are scanned, 1 for Screen 2 |

## Verification
A line pulse sampled at one rising edge shows its first fetch strobe after that edge. The strobes then run for exactly stride cycles. The bench releases the pulse on the next falling edge and samples there, and keeps sampling for stride+2 falling edges to confirm that the strobes stop. A region change or base reload shows up on the first strobe of the following line. A frame pulse or register write takes effect one edge after it is sampled. The bench therefore waits a full cycle before it issues the next line pulse.

// File: rtl/split_addr_pkg.sv
package split_addr_pkg;
  localparam int ADDR_W   = 16;
  localparam int REG_N    = 6;
  localparam logic [7:0] REG_BASE = 8'h0C;

  typedef struct packed {
    logic [ADDR_W-1:0] s1_start;
    logic [ADDR_W-1:0] s2_start;
    logic [15:0]       s1_lines;
  } split_cfg_t;
endpackage

// File: rtl/split_regs.sv
module split_regs
  import split_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       load,
  output split_cfg_t shadow_cfg,
  output split_cfg_t active_cfg
);
  logic [7:0] sh_q  [REG_N];
  logic [7:0] sh_d  [REG_N];
  logic [7:0] act_q [REG_N];

  for (genvar i = 0; i < REG_N; i++) begin : g_byte
    assign sh_d[i] = (we && (addr == REG_BASE + 8'(i))) ? wdata : sh_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q[i]  <= '0;
        act_q[i] <= '0;
      end else begin
        sh_q[i] <= sh_d[i];
        if (load) act_q[i] <= sh_q[i];
      end
    end
  end

  assign shadow_cfg = '{s1_start: {sh_q[1], sh_q[0]},
                        s2_start: {sh_q[3], sh_q[2]},
                        s1_lines: {sh_q[5], sh_q[4]}};
  assign active_cfg = '{s1_start: {act_q[1], act_q[0]},
                        s2_start: {act_q[3], act_q[2]},
                        s1_lines: {act_q[5], act_q[4]}};
endmodule

// File: rtl/split_word_ctr.sv
module split_word_ctr
  import split_addr_pkg::*;
#(
  parameter int STRIDE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                abort,
  input  logic                start,
  input  logic [ADDR_W-1:0]   base,
  input  logic [STRIDE_W-1:0] stride,
  output logic                fetch,
  output logic [ADDR_W-1:0]   word_addr,
  output logic                last
);
  logic                busy_q, busy_d;
  logic [STRIDE_W-1:0] idx_q, idx_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;

  assign last = busy_q && (idx_q == stride - 1'b1);

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    addr_d = addr_q;
    if (abort) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      addr_d = addr_q + 1'b1;
      idx_d  = idx_q + 1'b1;
      if (last) busy_d = 1'b0;
    end else if (start && (stride != '0)) begin
      busy_d = 1'b1;
      idx_d  = '0;
      addr_d = base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      addr_q <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      addr_q <= addr_d;
    end
  end

  assign fetch     = busy_q;
  assign word_addr = addr_q;
endmodule

// File: rtl/split_line_ctl.sv
module split_line_ctl
  import split_addr_pkg::*;
#(
  parameter int LINE_W   = 10,
  parameter int STRIDE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                portrait,
  input  logic [LINE_W-1:0]   panel_lines,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [ADDR_W-1:0]   first_start,
  input  logic [ADDR_W-1:0]   second_start,
  input  logic [LINE_W-1:0]   s1_lines,
  input  logic                line_done,
  output logic [ADDR_W-1:0]   line_base,
  output logic                line_ok,
  output logic                region
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [LINE_W-1:0] cnt_q, cnt_d;
  logic              reg_q, reg_d;
  logic              split_now;

  assign split_now = !portrait && (s1_lines < panel_lines) &&
                     ({1'b0, cnt_q} + 1'b1 == {1'b0, s1_lines});

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    reg_d  = reg_q;
    if (frame_start) begin
      base_d = first_start;
      cnt_d  = '0;
      reg_d  = 1'b0;
    end else if (line_done) begin
      cnt_d = cnt_q + 1'b1;
      if (split_now) begin
        base_d = second_start;
        reg_d  = 1'b1;
      end else begin
        base_d = base_q + ADDR_W'(stride);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      reg_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      reg_q  <= reg_d;
    end
  end

  assign line_base = base_q;
  assign line_ok   = cnt_q < panel_lines;
  assign region    = reg_q;
endmodule

// File: rtl/split_addr_gen.sv
module split_addr_gen
  import split_addr_pkg::*;
#(
  parameter int LINE_W   = 10,
  parameter int STRIDE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                line_start,
  input  logic [LINE_W-1:0]   panel_lines,
  input  logic [STRIDE_W-1:0] word_stride,
  input  logic                portrait,
  input  logic                reg_we,
  input  logic [7:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic                fetch,
  output logic [15:0]         word_addr,
  output logic                region
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  split_cfg_t        shadow_cfg, active_cfg;
  logic [ADDR_W-1:0] line_base;
  logic              line_ok, line_done, burst_go;

  split_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .load       (frame_start),
    .shadow_cfg (shadow_cfg),
    .active_cfg (active_cfg)
  );

  split_line_ctl #(.LINE_W(LINE_W), .STRIDE_W(STRIDE_W)) u_line (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .frame_start  (frame_start),
    .portrait     (portrait),
    .panel_lines  (panel_lines),
    .stride       (word_stride),
    .first_start  (shadow_cfg.s1_start),
    .second_start (active_cfg.s2_start),
    .s1_lines     (active_cfg.s1_lines[LINE_W-1:0]),
    .line_done    (line_done),
    .line_base    (line_base),
    .line_ok      (line_ok),
    .region       (region)
  );

  assign burst_go = line_start && line_ok;

  split_word_ctr #(.STRIDE_W(STRIDE_W)) u_word (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .abort     (frame_start),
    .start     (burst_go),
    .base      (line_base),
    .stride    (word_stride),
    .fetch     (fetch),
    .word_addr (word_addr),
    .last      (line_done)
  );
endmodule

// File: rtl/split_addr_chk.sv
module split_addr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start,
  input logic        line_start,
  input logic        portrait,
  input logic        fetch,
  input logic [15:0] word_addr,
  input logic        region
);
  AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) |-> (!fetch && !region)); // R2

  AST_FETCH_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch) |-> $past(line_start)); // R3

  AST_ADDR_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && $past(fetch)) |-> (word_addr == $past(word_addr) + 16'd1)); // R3

  AST_SPLIT_AT_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(region) |-> $past(fetch)); // R5

  AST_NO_SPLIT_PORTRAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(region) |-> !$past(portrait)); // R7
endmodule

bind split_addr_gen split_addr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .line_start  (line_start),
  .portrait    (portrait),
  .fetch       (fetch),
  .word_addr   (word_addr),
  .region      (region)
);

// File: tb/tb_split_addr_gen.sv
`timescale 1ns/1ps
module tb_split_addr_gen;
  localparam int LW = 10;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_start, line_start, portrait, reg_we;
  logic [LW-1:0] panel_lines;
  logic [SW-1:0] word_stride;
  logic [7:0]    reg_addr, reg_wdata;
  logic          fetch, region;
  logic [15:0]   word_addr;

  int n_chk = 0;
  int n_fail = 0;

  // bench model of the configuration in force for the current frame
  logic [15:0] m_s1, m_s2;
  int          m_sz;

  always #2.5 clk = ~clk;

  split_addr_gen #(.LINE_W(LW), .STRIDE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .panel_lines(panel_lines), .word_stride(word_stride), .portrait(portrait),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .fetch(fetch), .word_addr(word_addr), .region(region)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic set_regs(input logic [15:0] s1, input logic [15:0] s2, input int sz);
    wr(8'h0C, s1[7:0]); wr(8'h0D, s1[15:8]);
    wr(8'h0E, s2[7:0]); wr(8'h0F, s2[15:8]);
    wr(8'h10, 8'(sz));  wr(8'h11, 8'(sz >> 8));
  endtask

  task automatic frame_pulse();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    chk(!fetch && !region, "R2 frame pulse clears", {fetch, region}, 0);
  endtask

  function automatic bit m_split(int l);
    return !portrait && m_sz > 0 && m_sz < int'(panel_lines) && l >= m_sz;
  endfunction

  function automatic logic [15:0] m_base(int l);
    if (m_split(l)) return m_s2 + 16'((l - m_sz) * int'(word_stride));
    return m_s1 + 16'(l * int'(word_stride));
  endfunction

  // fire one line and compare its whole burst with the model
  task automatic do_line(input int l, input string req);
    int n = 0; int bad = 0; int reg_seen;
    logic [15:0] exp_a; logic [15:0] got_a;
    exp_a = m_base(l); got_a = 16'h0;
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    reg_seen = region;
    for (int k = 0; k < int'(word_stride) + 2; k++) begin
      if (fetch) begin
        if (n == 0) got_a = word_addr;
        if (word_addr != exp_a + 16'(n)) bad++;
        n++;
      end
      @(negedge clk);
    end
    chk(n == int'(word_stride), {req, " R3 fetch count"}, n, word_stride);
    chk(bad == 0 && got_a == exp_a, {req, " R3/R4 line base"}, got_a, exp_a);
    chk(reg_seen == int'(m_split(l)), {req, " R5 region flag"}, reg_seen, m_split(l));
  endtask

  task automatic no_fetch_line(input string req);
    int n = 0;
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    for (int k = 0; k < int'(word_stride) + 2; k++) begin
      if (fetch) n++;
      @(negedge clk);
    end
    chk(n == 0, req, n, 0);
  endtask

  task automatic run_frame(input string req);
    frame_pulse();
    for (int l = 0; l < int'(panel_lines); l++) do_line(l, req);
    no_fetch_line("R8 line beyond panel");
  endtask

  task automatic t_reset();
    chk(!fetch && !region && word_addr == 16'h0, "R2 reset state", {fetch, region}, 0);
  endtask

  task automatic t_split();
    portrait = 0; panel_lines = 6; word_stride = 4;
    set_regs(16'h4000, 16'h0010, 3);
    m_s1 = 16'h4000; m_s2 = 16'h0010; m_sz = 3;
    run_frame("R1 R5 split, lower second address");
  endtask

  task automatic t_same();
    set_regs(16'h0200, 16'h0200, 2);
    m_s1 = 16'h0200; m_s2 = 16'h0200; m_sz = 2;
    run_frame("R10 equal addresses");
  endtask

  task automatic t_full();
    set_regs(16'h1000, 16'h2000, 6);
    m_s1 = 16'h1000; m_s2 = 16'h2000; m_sz = 6;
    run_frame("R6 size equals panel");
    set_regs(16'h1000, 16'h2000, 300);
    m_sz = 300;
    run_frame("R6 size above panel");
  endtask

  task automatic t_portrait();
    set_regs(16'h0100, 16'h8000, 2);
    m_s1 = 16'h0100; m_s2 = 16'h8000; m_sz = 2;
    portrait = 1;
    run_frame("R7 portrait");
    portrait = 0;
  endtask

  task automatic t_wrap();
    word_stride = 3;
    set_regs(16'hFFFE, 16'h0000, 4);
    m_s1 = 16'hFFFE; m_s2 = 16'h0000; m_sz = 4;
    run_frame("R3 address wrap");
    word_stride = 4;
  endtask

  task automatic t_shadow();
    set_regs(16'h3000, 16'h5000, 2);
    m_s1 = 16'h3000; m_s2 = 16'h5000; m_sz = 2;
    frame_pulse();
    do_line(0, "R9 before write");
    set_regs(16'h7000, 16'h6000, 4);
    for (int l = 1; l < int'(panel_lines); l++) do_line(l, "R9 mid-frame write ignored");
    m_s1 = 16'h7000; m_s2 = 16'h6000; m_sz = 4;
    run_frame("R9 next frame uses new values");
  endtask

  task automatic t_bad_offset();
    wr(8'h0B, 8'hAA); wr(8'h12, 8'h55); wr(8'h8E, 8'h33);
    run_frame("R1 other offsets ignored");
  endtask

  task automatic t_busy_and_zero();
    int n = 0;
    frame_pulse();
    // second pulse during the burst must not extend or restart it
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    if (fetch) n++;
    @(negedge clk); line_start = 1'b1;
    if (fetch) n++;
    @(negedge clk); line_start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (fetch) n++;
      @(negedge clk);
    end
    chk(n == int'(word_stride), "R8 pulse while busy ignored", n, word_stride);
    word_stride = 0;
    no_fetch_line("R8 zero stride no fetch");
    word_stride = 4;
    do_line(1, "R8 zero stride did not advance");
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 0; line_start = 0; portrait = 0; reg_we = 0;
    reg_addr = 0; reg_wdata = 0; panel_lines = 6; word_stride = 4;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_split();
    t_same();
    t_full();
    t_portrait();
    t_wrap();
    t_shadow();
    t_bad_offset();
    t_busy_and_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule